// File: doc/BRIEF.md
# Logarithmic Attenuator Gain Control Loop

This block closes a digital automatic gain control loop around a logarithmic attenuator. The attenuator takes an 8-bit code and attenuates by 0.375 dB for each step of that code. Every code from 240 up means mute. An external detector supplies unsigned level samples, each marked by a valid strobe. On an update, the block compares the sample with a reference threshold and a symmetric deadband. A level above the window adds one step of attenuation. A level below the window removes one step. This negative feedback drives the average output level toward the reference.

A programmable divider sets the loop time constant: the code moves at most once every `div_i + 1` valid samples. The code saturates at 0 and at 239, so the loop never enters the mute band. If the input stays beyond the range of the attenuator, the code holds at a stable, known value instead of wrapping. Two flags report which end-stop has been reached. Reset loads a parameterised initial code.

Top module: `agc_loop_ctrl`

## Requirements
- R1: While `rst_ni` is low, `atten_o` equals INIT_CODE (default 120), both end-stop flags are low, and the divider count is cleared.
- R2: On an update, if `level_i > ref_i + deadband_i`, `atten_o` rises by exactly one on the following clock edge, unless it is already 239.
- R3: On an update, if `level_i + deadband_i < ref_i`, `atten_o` falls by exactly one on the following clock edge, unless it is already 0.
- R4: On an update where `ref_i - deadband_i <= level_i <= ref_i + deadband_i` (both limits inclusive), `atten_o` holds.
- R5: `atten_o` never exceeds 239. While it is 239, further upward requests leave it at 239.
- R6: While `atten_o` is 0, further downward requests leave it at 0.
- R7: A cycle with `level_vld_i` low never changes `atten_o` and never advances the divider.
- R8: An update happens only on a valid sample whose divider count has reached `div_i`, which means every `div_i + 1` valid samples. The count returns to zero after each update, and the valid samples in between leave `atten_o` unchanged.
- R9: `stop_hi_o` is high exactly when `atten_o` is 239. `stop_lo_o` is high exactly when `atten_o` is 0.
- R10: If `div_i` is lowered below the count already reached, the next valid sample causes an update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| level_vld_i | input | 1 | Level sample valid strobe |
| level_i | input | LEVEL_W (16) | Detected output level, unsigned |
| ref_i | input | LEVEL_W (16) | Reference level |
| deadband_i | input | LEVEL_W (16) | Half-width of the hold window |
| div_i | input | DIV_W (8) | Update once every div_i+1 valid samples |
| atten_o | output | CODE_W (8) | Attenuation code, 0.375 dB per step |
| stop_hi_o | output | 1 | Code held at the top end-stop (239) |
| stop_lo_o | output | 1 | Code held at the bottom end-stop (0) |

## Verification
Any fault in the code register appears on `atten_o` on the clock edge right after the update that caused it. The flags follow that register without delay, so a wrong end-stop shows up as a code of 240 or above, or as a wrapped code, in that same cycle. A divider that is one count off changes the spacing of updates, and this shows within one divider period of any run of valid samples. A deadband fault shows as a step on a sample that sits exactly on a window limit. The bench compares the ports with a behavioural model on every cycle. It also closes the loop through a dB-scaled plant, and both end-stops are driven into saturation.

// File: rtl/agc_pkg.sv
package agc_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } agc_dir_t;
endpackage

// File: rtl/agc_compare.sv
module agc_compare
  import agc_pkg::*;
#(
  parameter int LEVEL_W = 16
) (
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0] ref_i,
  input  logic [LEVEL_W-1:0] deadband_i,
  output agc_dir_t           dir_o
);
  localparam int EXT_W = LEVEL_W + 1;

  logic [EXT_W-1:0] hi_lim;
  logic [EXT_W-1:0] lvl_plus_db;
  logic             above, below;

  assign hi_lim      = {1'b0, ref_i} + {1'b0, deadband_i};
  assign lvl_plus_db = {1'b0, level_i} + {1'b0, deadband_i};
  assign above       = {1'b0, level_i} > hi_lim;
  assign below       = lvl_plus_db < {1'b0, ref_i};

  always_comb begin
    if (above)      dir_o = DIR_UP;
    else if (below) dir_o = DIR_DN;
    else            dir_o = DIR_HOLD;
  end
endmodule

// File: rtl/agc_divider.sv
module agc_divider #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  // >= so a lowered divisor fires on the next sample
  assign tick_o = vld_i && (cnt_q >= div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else if (vld_i)  cnt_q <= cnt_q + 1'b1;
  end

  // R8
  tick_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> cnt_q == '0);
  // R7
  idle_cnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(cnt_q));
endmodule

// File: rtl/agc_code_ctr.sv
module agc_code_ctr
  import agc_pkg::*;
#(
  parameter int CODE_W    = 8,
  parameter int CODE_MAX  = 239,
  parameter int INIT_CODE = 120
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  input  agc_dir_t          dir_i,
  output logic [CODE_W-1:0] code_o,
  output logic              at_max_o,
  output logic              at_min_o
);
  localparam logic [CODE_W-1:0] MAX_C  = CODE_W'(CODE_MAX);
  localparam logic [CODE_W-1:0] INIT_C = CODE_W'(INIT_CODE);

  logic [CODE_W-1:0] code_q;

  assign at_max_o = (code_q == MAX_C);
  assign at_min_o = (code_q == '0);
  assign code_o   = code_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= INIT_C;
    end else if (step_i) begin
      if (dir_i == DIR_UP && !at_max_o)      code_q <= code_q + 1'b1;
      else if (dir_i == DIR_DN && !at_min_o) code_q <= code_q - 1'b1;
    end
  end

  // R5
  code_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    code_q <= MAX_C);
  // R7
  code_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(code_q));
  // R2
  code_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && dir_i == DIR_UP && code_q < MAX_C |=> code_q == $past(code_q) + 1'b1);
  // R6
  code_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && dir_i == DIR_DN && code_q == '0 |=> code_q == '0);
endmodule

// File: rtl/agc_loop_ctrl.sv
module agc_loop_ctrl
  import agc_pkg::*;
#(
  parameter int LEVEL_W    = 16,
  parameter int DIV_W      = 8,
  parameter int CODE_W     = 8,
  parameter int MUTE_START = 240,
  parameter int INIT_CODE  = 120
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               level_vld_i,
  input  logic [LEVEL_W-1:0] level_i,
  input  logic [LEVEL_W-1:0] ref_i,
  input  logic [LEVEL_W-1:0] deadband_i,
  input  logic [DIV_W-1:0]   div_i,
  output logic [CODE_W-1:0]  atten_o,
  output logic               stop_hi_o,
  output logic               stop_lo_o
);
  localparam int CODE_MAX = MUTE_START - 1;

  agc_dir_t dir;
  logic     tick;

  agc_compare #(.LEVEL_W(LEVEL_W)) u_cmp (
    .level_i    (level_i),
    .ref_i      (ref_i),
    .deadband_i (deadband_i),
    .dir_o      (dir)
  );

  agc_divider #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (level_vld_i),
    .div_i  (div_i),
    .tick_o (tick)
  );

  agc_code_ctr #(
    .CODE_W    (CODE_W),
    .CODE_MAX  (CODE_MAX),
    .INIT_CODE (INIT_CODE)
  ) u_ctr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (tick),
    .dir_i    (dir),
    .code_o   (atten_o),
    .at_max_o (stop_hi_o),
    .at_min_o (stop_lo_o)
  );

  // R9
  stop_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stop_hi_o && stop_lo_o));
  // R4
  window_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && dir == DIR_HOLD |=> $stable(atten_o));
  // R3
  down_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick && level_i < ref_i && dir == DIR_DN && !stop_lo_o
      |=> atten_o == $past(atten_o) - 1'b1);
endmodule

// File: tb/sim_agc_loop_ctrl.sv
module sim_agc_loop_ctrl;
  localparam int LW = 16;
  localparam int DW = 8;
  localparam int INIT = 120;
  localparam int CMAX = 239;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          level_vld_i = 1'b0;
  logic [LW-1:0] level_i = '0;
  logic [LW-1:0] ref_i = '0;
  logic [LW-1:0] deadband_i = '0;
  logic [DW-1:0] div_i = '0;
  logic [7:0]    atten_o;
  logic          stop_hi_o, stop_lo_o;

  int n_chk = 0;
  int n_fail = 0;
  int m_code = INIT;
  int m_cnt = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  agc_loop_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .level_vld_i(level_vld_i),
    .level_i(level_i), .ref_i(ref_i), .deadband_i(deadband_i), .div_i(div_i),
    .atten_o(atten_o), .stop_hi_o(stop_hi_o), .stop_lo_o(stop_lo_o)
  );

  task automatic check(string tag);
    logic [9:0] exp_v, act_v;
    exp_v = {m_code[7:0], (m_code == CMAX), (m_code == 0)};
    act_v = {atten_o, stop_hi_o, stop_lo_o};
    n_chk++;
    if (act_v !== exp_v) begin
      n_fail++;
      $display("FAIL %s: code/hi/lo actual %0d/%0b/%0b expected %0d/%0b/%0b",
               tag, atten_o, stop_hi_o, stop_lo_o, m_code, m_code == CMAX, m_code == 0);
    end
  endtask

  // called at a negedge: drive, advance model, sample after the edge
  task automatic step(bit vld, int lvl, string tag);
    level_vld_i = vld;
    level_i     = LW'(lvl);
    if (vld) begin
      if (m_cnt >= int'(div_i)) begin
        m_cnt = 0;
        if (lvl > int'(ref_i) + int'(deadband_i)) begin
          if (m_code < CMAX) m_code++;
        end else if (lvl + int'(deadband_i) < int'(ref_i)) begin
          if (m_code > 0) m_code--;
        end
      end else begin
        m_cnt++;
      end
    end
    @(posedge clk_i);
    @(negedge clk_i);
    check(tag);
  endtask

  function automatic int plant(int amp, int code);
    real g;
    g = $pow(10.0, -0.375 * real'(code) / 20.0);
    return $rtoi(real'(amp) * g);
  endfunction

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1");
    rst_ni = 1'b1;
    ref_i = 16'd1000; deadband_i = 16'd100; div_i = 8'd0;
    step(1'b1, 2000, "R2");
    step(1'b1, 2000, "R2");
    step(1'b1, 500,  "R3");
    step(1'b1, 1100, "R4");
    step(1'b1, 900,  "R4");
    step(1'b1, 1101, "R2");
    step(1'b1, 899,  "R3");
    for (int i = 0; i < 5; i++) step(1'b0, 5000, "R7");
    div_i = 8'd3;
    for (int i = 0; i < 12; i++) step(1'b1, 3000, "R8");
    step(1'b1, 3000, "R8");
    step(1'b1, 3000, "R8");
    step(1'b1, 3000, "R8");
    div_i = 8'd1;
    step(1'b1, 3000, "R10");
    step(1'b1, 3000, "R10");
    div_i = 8'd0;
    for (int i = 0; i < 140; i++) step(1'b1, 60000, "R5");
    for (int i = 0; i < 5; i++) step(1'b1, 60000, "R9");
    for (int i = 0; i < 250; i++) step(1'b1, 0, "R6");
    for (int i = 0; i < 5; i++) step(1'b1, 0, "R9");
    ref_i = 16'd1000; deadband_i = 16'd60;
    for (int i = 0; i < 300; i++) step(1'b1, plant(20000, int'(atten_o)), "R2");
    begin
      int y;
      y = plant(20000, int'(atten_o));
      n_chk++;
      if (y > 1060 || y < 940) begin
        n_fail++;
        $display("FAIL R3: converged level actual %0d expected 940..1060", y);
      end
    end
    rst_ni = 1'b0;
    m_code = INIT; m_cnt = 0;
    @(negedge clk_i);
    check("R1");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule